// File: doc/BRIEF.md
# Eight-bit ALU with flag generation

This block is the arithmetic and logic unit of a small eight-bit processor core. Each cycle it takes an operation code, the accumulator value, a second operand (usually a data-memory byte), and the current carry and auxiliary-carry flags. It computes the result byte, the next values of the carry (C), auxiliary carry (AC), zero (Z) and overflow (OV) flags, and a skip indication for the conditional-skip operations. Each flag is paired with a write enable, so the surrounding core changes only the flags that the operation defines. The core also handles the writeback of the result and any program-counter skip.

All outputs are registered. They appear one clock after the inputs are presented. A synchronous active-high reset clears them. Single-operand operations (complement, rotates, increment, decrement and the skip tests) act on the second operand. Decimal adjust acts on the accumulator.

Top module: `alu8_core`

## Requirements
- R1: Outputs are registered, so a result appears on the outputs one clock after its inputs. While `rst` is high at a rising edge, every output is cleared to 0.
- R2: The operation codes on `op_i` are: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 DAA, 5 AND, 6 OR, 7 XOR, 8 CPL, 9 RL, 10 RR, 11 RLC, 12 RRC, 13 INC, 14 DEC, 15 SZ, 16 SNZ, 17 SIZ, 18 SDZ. A flag value output whose write enable is low reads 0.
- R3: ADD gives acc+opnd and ADC gives acc+opnd+C. C is the carry out of bit 7. AC is the carry out of bit 3.
- R4: SUB gives acc−opnd and SBC gives acc−opnd−(1−C). C is 1 when no borrow occurs. AC is 1 when the low nibble needs no borrow from the high nibble.
- R5: For the four add and subtract operations, OV is the carry into bit 7 XOR the carry out of bit 7. Z is set when the result byte is zero. All four flag enables are high.
- R6: DAA first adds 06h to the accumulator if AC is 1 or its low nibble exceeds 9. It then adds 60h if C is 1, if the first step carried, or if the high nibble of the intermediate value exceeds 9. The new C is 1 only if either step carried out of bit 7. Only C is enabled.
- R7: AND, OR and XOR combine acc with opnd, and CPL gives the bitwise inverse of opnd. These four operations enable only Z.
- R8: RL and RR rotate opnd left or right by one bit and enable no flag.
- R9: RLC and RRC rotate opnd through C. The bit shifted out (bit 7 for RLC, bit 0 for RRC) becomes the new C. Only C is enabled.
- R10: INC and DEC give opnd+1 and opnd−1 modulo 256 and enable only Z.
- R11: SZ and SNZ pass opnd through as the result and enable no flag. Skip is 1 when opnd is zero for SZ, and when opnd is nonzero for SNZ.
- R12: SIZ and SDZ give opnd+1 and opnd−1 modulo 256 and enable no flag. Skip is 1 when that result is zero.
- R13: Codes 19 to 31 give result 0, no flag enable and no skip. Operations other than the four skip tests never raise skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| acc_i | input | 8 | Accumulator operand |
| opnd_i | input | 8 | Second operand |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | Next carry value |
| c_we_o | output | 1 | Carry write enable |
| ac_o | output | 1 | Next auxiliary carry value |
| ac_we_o | output | 1 | Auxiliary carry write enable |
| z_o | output | 1 | Next zero flag value |
| z_we_o | output | 1 | Zero flag write enable |
| ov_o | output | 1 | Next overflow value |
| ov_we_o | output | 1 | Overflow write enable |
| skip_o | output | 1 | Skip indication |

## Verification
The assertions assume that `op_i`, the operands and the flag inputs carry known values and stay steady across each rising edge, because several properties compare an output with the previous cycle's input through `$past`. The bench changes every input only on the falling edge and never drives X. Its random phase draws operation codes from the full 5-bit range, so the undefined codes that the properties must also tolerate are included. The reference model sees the same values one cycle earlier, which matches the single register stage.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned NW = DW / 2;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_DAA = 5'd4,  OP_AND = 5'd5,  OP_OR  = 5'd6,  OP_XOR = 5'd7,
    OP_CPL = 5'd8,  OP_RL  = 5'd9,  OP_RR  = 5'd10, OP_RLC = 5'd11,
    OP_RRC = 5'd12, OP_INC = 5'd13, OP_DEC = 5'd14, OP_SZ  = 5'd15,
    OP_SNZ = 5'd16, OP_SIZ = 5'd17, OP_SDZ = 5'd18
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          c_we;
    logic          ac;
    logic          ac_we;
    logic          z;
    logic          z_we;
    logic          ov;
    logic          ov_we;
    logic          skip;
  } alu_res_t;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         c_out,
  output logic         ac_out,
  output logic         ov_out
);
  logic [W-1:0] bx;
  logic [W:0]   full;
  logic         c_into_msb;

  // subtraction as a + ~b + cin: carry out means "no borrow"
  assign bx   = sub ? ~b : b;
  assign full = {1'b0, a} + {1'b0, bx} + {{W{1'b0}}, cin};
  assign sum  = full[W-1:0];

  // carry into a bit position is recovered from the sum bit and both inputs
  assign c_into_msb = a[W-1] ^ bx[W-1] ^ full[W-1];
  assign ac_out     = a[NW] ^ bx[NW] ^ full[NW];
  assign c_out      = full[W];
  assign ov_out     = c_into_msb ^ full[W];
endmodule

// File: rtl/alu8_daa.sv
module alu8_daa #(
  parameter int unsigned W  = 8,
  parameter int unsigned NW = W / 2
) (
  input  logic [W-1:0] a,
  input  logic         c_in,
  input  logic         ac_in,
  output logic [W-1:0] res,
  output logic         c_out
);
  localparam logic [W:0]  LO_ADJ = (W+1)'(6);
  localparam logic [W:0]  HI_ADJ = (W+1)'(6) << NW;
  localparam logic [NW-1:0] DIG_MAX = NW'(9);

  logic [W:0] step1, step2;
  logic       lo_fix, hi_fix;

  always_comb begin
    lo_fix = ac_in | (a[NW-1:0] > DIG_MAX);
    step1  = {1'b0, a} + (lo_fix ? LO_ADJ : '0);
    hi_fix = c_in | step1[W] | (step1[W-1:NW] > DIG_MAX);
    step2  = {1'b0, step1[W-1:0]} + (hi_fix ? HI_ADJ : '0);
    res    = step2[W-1:0];
    c_out  = step1[W] | step2[W];
  end
endmodule

// File: rtl/alu8_unary.sv
module alu8_unary
  import alu8_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic [4:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         c_in,
  output alu_res_t     r
);
  logic [W-1:0] b_inc, b_dec;
  assign b_inc = b + W'(1);
  assign b_dec = b - W'(1);

  always_comb begin
    r = '0;
    case (op)
      OP_AND: begin r.res = a & b; r.z_we = 1'b1; end
      OP_OR:  begin r.res = a | b; r.z_we = 1'b1; end
      OP_XOR: begin r.res = a ^ b; r.z_we = 1'b1; end
      OP_CPL: begin r.res = ~b;    r.z_we = 1'b1; end
      OP_RL:  r.res = {b[W-2:0], b[W-1]};
      OP_RR:  r.res = {b[0], b[W-1:1]};
      OP_RLC: begin r.res = {b[W-2:0], c_in}; r.c = b[W-1]; r.c_we = 1'b1; end
      OP_RRC: begin r.res = {c_in, b[W-1:1]}; r.c = b[0];   r.c_we = 1'b1; end
      OP_INC: begin r.res = b_inc; r.z_we = 1'b1; end
      OP_DEC: begin r.res = b_dec; r.z_we = 1'b1; end
      OP_SZ:  begin r.res = b;     r.skip = (b == '0); end
      OP_SNZ: begin r.res = b;     r.skip = (b != '0); end
      OP_SIZ: begin r.res = b_inc; r.skip = (b_inc == '0); end
      OP_SDZ: begin r.res = b_dec; r.skip = (b_dec == '0); end
      default: ;
    endcase
    r.z = r.z_we & (r.res == '0);
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic [4:0]    op_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] opnd_i,
  input  logic          c_i,
  input  logic          ac_i,
  output logic [DW-1:0] res_o,
  output logic          c_o,
  output logic          c_we_o,
  output logic          ac_o,
  output logic          ac_we_o,
  output logic          z_o,
  output logic          z_we_o,
  output logic          ov_o,
  output logic          ov_we_o,
  output logic          skip_o
);
  logic          is_arith, as_sub, as_cin;
  logic [DW-1:0] as_sum, daa_res;
  logic          as_c, as_ac, as_ov, daa_c;
  alu_res_t      un_r, nxt, q;

  assign is_arith = (op_i == OP_ADD) || (op_i == OP_ADC) ||
                    (op_i == OP_SUB) || (op_i == OP_SBC);
  assign as_sub   = (op_i == OP_SUB) || (op_i == OP_SBC);

  always_comb begin
    case (op_i)
      OP_ADD:  as_cin = 1'b0;
      OP_SUB:  as_cin = 1'b1;
      default: as_cin = c_i;
    endcase
  end

  alu8_addsub #(.W(DW), .NW(NW)) u_addsub (
    .a(acc_i), .b(opnd_i), .sub(as_sub), .cin(as_cin),
    .sum(as_sum), .c_out(as_c), .ac_out(as_ac), .ov_out(as_ov)
  );

  alu8_daa #(.W(DW), .NW(NW)) u_daa (
    .a(acc_i), .c_in(c_i), .ac_in(ac_i), .res(daa_res), .c_out(daa_c)
  );

  alu8_unary #(.W(DW)) u_unary (
    .op(op_i), .a(acc_i), .b(opnd_i), .c_in(c_i), .r(un_r)
  );

  always_comb begin
    nxt = un_r;
    if (is_arith) begin
      nxt       = '0;
      nxt.res   = as_sum;
      nxt.c     = as_c;   nxt.c_we  = 1'b1;
      nxt.ac    = as_ac;  nxt.ac_we = 1'b1;
      nxt.ov    = as_ov;  nxt.ov_we = 1'b1;
      nxt.z     = (as_sum == '0);
      nxt.z_we  = 1'b1;
    end else if (op_i == OP_DAA) begin
      nxt      = '0;
      nxt.res  = daa_res;
      nxt.c    = daa_c;
      nxt.c_we = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  assign res_o   = q.res;
  assign c_o     = q.c;
  assign c_we_o  = q.c_we;
  assign ac_o    = q.ac;
  assign ac_we_o = q.ac_we;
  assign z_o     = q.z;
  assign z_we_o  = q.z_we;
  assign ov_o    = q.ov;
  assign ov_we_o = q.ov_we;
  assign skip_o  = q.skip;

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (res_o == '0) && !c_we_o && !z_we_o && !skip_o);

  p_flag_gated_r2: assert property (@(posedge clk) disable iff (rst)
    (!c_we_o |-> !c_o) and (!ac_we_o |-> !ac_o) and
    (!z_we_o |-> !z_o) and (!ov_we_o |-> !ov_o));

  p_arith_all_we_r5: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {OP_ADD, OP_ADC, OP_SUB, OP_SBC}) |=>
      c_we_o && ac_we_o && z_we_o && ov_we_o && (z_o == (res_o == '0)));

  p_daa_c_only_r6: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_DAA) |=> c_we_o && !ac_we_o && !z_we_o && !ov_we_o);

  p_logic_z_only_r7: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {OP_AND, OP_OR, OP_XOR, OP_CPL}) |=>
      z_we_o && !c_we_o && !ac_we_o && !ov_we_o && !skip_o);

  p_plain_rot_r8: assert property (@(posedge clk) disable iff (rst)
    (op_i inside {OP_RL, OP_RR}) |=>
      !c_we_o && !ac_we_o && !z_we_o && !ov_we_o);

  p_rlc_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RLC) |=> c_we_o && (c_o == $past(opnd_i[DW-1])) &&
                         (res_o[0] == $past(c_i)));

  p_rrc_carry_r9: assert property (@(posedge clk) disable iff (rst)
    (op_i == OP_RRC) |=> c_we_o && (c_o == $past(opnd_i[0])) &&
                         (res_o[DW-1] == $past(c_i)));

  p_skip_source_r13: assert property (@(posedge clk) disable iff (rst)
    !(op_i inside {OP_SZ, OP_SNZ, OP_SIZ, OP_SDZ}) |=> !skip_o);
endmodule

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [4:0] op_i;
  logic [7:0] acc_i, opnd_i;
  logic       c_i, ac_i;
  logic [7:0] res_o;
  logic       c_o, c_we_o, ac_o, ac_we_o, z_o, z_we_o, ov_o, ov_we_o, skip_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  alu8_core dut_i (
    .clk(clk), .rst(rst), .op_i(op_i), .acc_i(acc_i), .opnd_i(opnd_i),
    .c_i(c_i), .ac_i(ac_i), .res_o(res_o), .c_o(c_o), .c_we_o(c_we_o),
    .ac_o(ac_o), .ac_we_o(ac_we_o), .z_o(z_o), .z_we_o(z_we_o),
    .ov_o(ov_o), .ov_we_o(ov_we_o), .skip_o(skip_o)
  );

  // expected vector: res, c, cwe, ac, acwe, z, zwe, ov, ovwe, skip
  int    e[10];
  string e_tag;
  bit    have_exp = 0;

  function automatic string tag_of(int op);
    if (op <= 1)  return "R3/R5";
    if (op <= 3)  return "R4/R5";
    if (op == 4)  return "R6";
    if (op <= 8)  return "R7";
    if (op <= 10) return "R8";
    if (op <= 12) return "R9";
    if (op <= 14) return "R10";
    if (op <= 16) return "R11";
    if (op <= 18) return "R12";
    return "R13";
  endfunction

  task automatic model(input int op, input int a, input int b, input int c,
                       input int ac);
    for (int i = 0; i < 10; i++) e[i] = 0;
    case (op)
      0, 1, 2, 3: begin
        int bb, ci, s;
        bb = (op >= 2) ? (255 - b) : b;
        ci = (op == 0) ? 0 : (op == 2) ? 1 : c;
        s  = a + bb + ci;
        e[0] = s % 256;
        e[1] = (s > 255);
        e[3] = ((a % 16) + (bb % 16) + ci) > 15;
        e[7] = (((a % 128) + (bb % 128) + ci) > 127) ^ e[1];
        e[5] = (e[0] == 0);
        e[2] = 1; e[4] = 1; e[6] = 1; e[8] = 1;
      end
      4: begin
        int s1, s2, cy;
        s1 = a; cy = 0;
        if (ac != 0 || (a % 16) > 9) s1 = a + 6;
        if (s1 > 255) cy = 1;
        s2 = s1 % 256;
        if (c != 0 || cy != 0 || (s2 / 16) > 9) s2 = s2 + 96;
        if (s2 > 255) cy = 1;
        e[0] = s2 % 256; e[1] = cy; e[2] = 1;
      end
      5:  begin e[0] = a & b;  e[6] = 1; end
      6:  begin e[0] = a | b;  e[6] = 1; end
      7:  begin e[0] = a ^ b;  e[6] = 1; end
      8:  begin e[0] = 255 - b; e[6] = 1; end
      9:  e[0] = ((b * 2) % 256) + (b / 128);
      10: e[0] = (b / 2) + (b % 2) * 128;
      11: begin e[0] = ((b * 2) % 256) + c; e[1] = b / 128; e[2] = 1; end
      12: begin e[0] = (b / 2) + c * 128;   e[1] = b % 2;   e[2] = 1; end
      13: begin e[0] = (b + 1) % 256;   e[6] = 1; end
      14: begin e[0] = (b + 255) % 256; e[6] = 1; end
      15: begin e[0] = b; e[9] = (b == 0); end
      16: begin e[0] = b; e[9] = (b != 0); end
      17: begin e[0] = (b + 1) % 256;   e[9] = (e[0] == 0); end
      18: begin e[0] = (b + 255) % 256; e[9] = (e[0] == 0); end
      default: ;
    endcase
    if (e[6] != 0 && e[5] == 0) e[5] = (e[0] == 0);
  endtask

  task automatic compare();
    int g[10];
    bit bad;
    g[0] = res_o; g[1] = c_o; g[2] = c_we_o; g[3] = ac_o; g[4] = ac_we_o;
    g[5] = z_o;   g[6] = z_we_o; g[7] = ov_o; g[8] = ov_we_o; g[9] = skip_o;
    bad = 0;
    for (int i = 0; i < 10; i++) if (g[i] != e[i]) bad = 1;
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL %s (R2 flag/enable fields): got res=%02h c=%0d/%0d ac=%0d/%0d z=%0d/%0d ov=%0d/%0d skip=%0d exp res=%02h c=%0d/%0d ac=%0d/%0d z=%0d/%0d ov=%0d/%0d skip=%0d",
               e_tag, g[0], g[1], g[2], g[3], g[4], g[5], g[6], g[7], g[8], g[9],
               e[0], e[1], e[2], e[3], e[4], e[5], e[6], e[7], e[8], e[9]);
    end
  endtask

  task automatic step(input bit r, input int op, input int a, input int b,
                      input int c, input int ac);
    @(negedge clk);
    if (have_exp) compare();
    rst = r; op_i = 5'(op); acc_i = 8'(a); opnd_i = 8'(b);
    c_i = c[0]; ac_i = ac[0];
    if (r) begin
      for (int i = 0; i < 10; i++) e[i] = 0;
      e_tag = "R1";
    end else begin
      model(op, a, b, c, ac);
      e_tag = tag_of(op);
    end
    have_exp = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; op_i = '0; acc_i = '0; opnd_i = '0; c_i = 1'b0; ac_i = 1'b0;
    // R1: reset with busy inputs must still clear everything
    step(1, 0, 8'hFF, 8'h01, 1, 1);
    step(1, 15, 8'h00, 8'h00, 1, 1);
    step(1, 11, 8'h80, 8'h80, 1, 1);
    // R3 / R5 adds
    step(0, 0, 8'h7F, 8'h01, 0, 0);
    step(0, 0, 8'hFF, 8'h01, 0, 0);
    step(0, 1, 8'h0F, 8'h00, 1, 0);
    step(0, 0, 8'h80, 8'h80, 0, 0);
    // R4 subtracts
    step(0, 2, 8'h05, 8'h05, 0, 0);
    step(0, 2, 8'h03, 8'h05, 1, 0);
    step(0, 2, 8'h80, 8'h01, 0, 0);
    step(0, 3, 8'h10, 8'h01, 0, 0);
    step(0, 3, 8'h10, 8'h01, 1, 0);
    // R6 decimal adjust
    step(0, 4, 8'h9A, 8'h00, 0, 0);
    step(0, 4, 8'h15, 8'h00, 0, 1);
    step(0, 4, 8'h23, 8'h00, 1, 0);
    step(0, 4, 8'hFF, 8'h00, 0, 0);
    // R7 logic
    step(0, 5, 8'hF0, 8'h0F, 1, 1);
    step(0, 6, 8'h00, 8'h00, 0, 0);
    step(0, 7, 8'hAA, 8'hAA, 0, 0);
    step(0, 8, 8'h00, 8'hFF, 0, 0);
    // R8, R9 rotates
    step(0, 9,  8'h00, 8'h81, 1, 0);
    step(0, 10, 8'h00, 8'h81, 1, 0);
    step(0, 11, 8'h00, 8'h80, 0, 0);
    step(0, 12, 8'h00, 8'h01, 1, 0);
    // R10 inc/dec wrap
    step(0, 13, 8'h00, 8'hFF, 0, 0);
    step(0, 14, 8'h00, 8'h00, 0, 0);
    // R11, R12 skips
    step(0, 15, 8'h00, 8'h00, 0, 0);
    step(0, 16, 8'h00, 8'h00, 0, 0);
    step(0, 16, 8'h00, 8'h40, 0, 0);
    step(0, 17, 8'h00, 8'hFF, 0, 0);
    step(0, 18, 8'h00, 8'h01, 0, 0);
    step(0, 18, 8'h00, 8'h00, 0, 0);
    // R13 undefined codes
    step(0, 19, 8'hFF, 8'hFF, 1, 1);
    step(0, 31, 8'h00, 8'h00, 1, 1);
    // mixed patterns across all codes
    for (int n = 0; n < 4000; n++)
      step(0, int'($urandom % 32), int'($urandom % 256), int'($urandom % 256),
           int'($urandom % 2), int'($urandom % 2));
    // reset again mid-stream (R1)
    step(1, 0, 8'h12, 8'h34, 1, 1);
    step(0, 0, 8'h00, 8'h00, 0, 0);
    @(negedge clk);
    compare();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule